// File: doc/BRIEF.md
# Oversampled Manchester Line Decoder with Pulse Squelch

The block takes a 10 Mb/s Manchester-coded line that has already been sampled by a faster clock (one sample per `clk` cycle, `OSR` samples per bit, eight by default) and turns it back into NRZ bits. Each bit comes out with a one-cycle strobe, and a carrier flag shows when a qualified signal is present. Noise is kept away from the decoder in two stages. A width filter removes any pulse shorter than `MIN_PULSE` samples. A pulse-width squelch then opens only after a run of transitions whose spacing matches Manchester timing.

Line encoding: a `1` bit is low in its first half and high in its second half, so its mid-bit transition is rising. A `0` bit is the reverse, with a falling mid-bit transition. A transition at a bit boundary happens only between two equal bits and carries no data. The decoder measures the time between filtered transitions. A long spacing (about one bit) marks a mid-bit transition. A short spacing (about half a bit) means the class changed from the previous transition.

A bit clock output runs all the time, through reset release, idle gaps and frames. It is high for the second half of each bit and is pulled back into phase at every recognised mid-bit transition. Downstream logic can therefore time against it even when no frame is present.

Top module: `manch_rx`

## Requirements
- R1: While `rst_n` is low at a clock edge, `carrier`, `rx_valid` and `rx_clk` go low and the squelch qualification count is cleared.
- R2: A pulse of fewer than 3 consecutive samples on `line_in` does not change the filtered line level. It causes no carrier, no strobe and no change to later decoded data.
- R3: Transition spacings of 3 to 5 samples (short) and 7 to 9 samples (long) are valid. Any other spacing, including the first transition after a long idle, clears the qualification count. `carrier` rises on the 4th consecutive valid transition, provided that transition is a known mid-bit one. With only 3 valid transitions, `carrier` stays low.
- R4: Each output bit equals the direction of its mid-bit transition: rising gives `rx_data` = 1 and falling gives 0. `rx_data` is meaningful only while `rx_valid` is high.
- R5: The transition that opens the squelch produces no bit. Output starts with the next mid-bit transition. A frame that starts from a low idle line with the alternating pattern 1,0,1,0,... loses its first 5 bits to qualification.
- R6: `rx_valid` is a single-cycle pulse, produced once per decoded bit and only while `carrier` is high.
- R7: `carrier` falls when no mid-bit transition has been seen for `CLOSE_BITS` × `OSR` samples (16 by default). Half a bit after the last transition of a frame, it is still high.
- R8: `rx_clk` runs freely with a period of `OSR` cycles while the line is idle or the squelch is closed. It is low for the first half of the bit and high for the second half.
- R9: At every recognised mid-bit transition the bit phase is reloaded to the middle of the bit. As a result, `rx_clk` is high in every cycle in which `rx_valid` is high, and bit lengths of 7 to 9 samples decode correctly.
- R10: A long spacing marks a transition as mid-bit, and a short spacing marks it as the opposite class to the one before. Boundary transitions, as in a run of equal bits, produce no output bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock, one line sample per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| line_in | input | 1 | Sampled Manchester line |
| rx_clk | output | 1 | Free-running recovered bit clock, high in the second half of the bit |
| rx_data | output | 1 | Decoded NRZ bit |
| rx_valid | output | 1 | One-cycle strobe per decoded bit |
| carrier | output | 1 | Squelch open (carrier sense) |

## Verification
The hardest situations to reach are the edges of squelch qualification: exactly three valid transitions, which must not open it, against four, which must open it but yield no bit. The stimulus uses short alternating preambles of four and five bits that start from a low idle line, so the first transition is always unreferenced. A second hard case is a noise pulse placed inside a long constant run, after the width filter has already committed to the level. The bench builds it from a 0 bit that follows a 1 bit, which gives eight equal samples, and flips two of them. Jittered bit lengths of 7, 8 and 9 samples are scored bit by bit against a queue.

// File: rtl/mrx_pkg.sv
// Shared types for the Manchester line decoder.
package mrx_pkg;

    // Class of the spacing between two filtered line transitions.
    typedef enum logic [1:0] {
        IV_NONE  = 2'd0,   // no transition this cycle
        IV_SHORT = 2'd1,   // about half a bit
        IV_LONG  = 2'd2,   // about one bit
        IV_BAD   = 2'd3    // outside both windows
    } ivl_class_t;

endpackage

// File: rtl/mrx_glitch_filter.sv
// Width filter on the sampled line.
// The filtered level follows the input only after the input has held a
// new value for MIN_PULSE consecutive samples. Shorter pulses vanish.
// Assumes MIN_PULSE >= 2 and that real line pulses are at least MIN_PULSE wide.
module mrx_glitch_filter #(
    parameter int MIN_PULSE = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level_o
);
    localparam int CW = $clog2(MIN_PULSE + 1);

    logic [CW-1:0] run_q;
    logic          level_q;

    // Count samples that differ from the committed level; commit on MIN_PULSE.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= 1'b0;
            run_q   <= '0;
        end else if (din != level_q) begin
            if (run_q == CW'(MIN_PULSE - 1)) begin
                level_q <= din;
                run_q   <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end else begin
            run_q <= '0;
        end
    end

    assign level_o = level_q;

endmodule

// File: rtl/mrx_edge_timer.sv
// Detects transitions of the filtered line and classifies the spacing to
// the previous transition as short, long or bad (tolerance TOL samples).
// Assumes the filtered level resets low, so no edge appears at reset.
module mrx_edge_timer
    import mrx_pkg::*;
#(
    parameter int OSR = 8,
    parameter int TOL = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       level_i,
    output logic       edge_o,
    output logic       rise_o,
    output ivl_class_t cls_o
);
    localparam int HALF = OSR / 2;
    localparam int IMAX = 2 * OSR;
    localparam int IW   = $clog2(IMAX + 1);

    logic          level_d;
    logic [IW-1:0] ivl_q;
    logic          in_short, in_long;

    // Delay the level for edge detection and time the gap between edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_d <= 1'b0;
            ivl_q   <= IW'(IMAX);
        end else begin
            level_d <= level_i;
            if (level_i != level_d) begin
                ivl_q <= IW'(1);
            end else if (ivl_q != IW'(IMAX)) begin
                ivl_q <= ivl_q + 1'b1;
            end
        end
    end

    // Window tests on the elapsed gap.
    always_comb begin
        in_short = (ivl_q >= IW'(HALF - TOL)) && (ivl_q <= IW'(HALF + TOL));
        in_long  = (ivl_q >= IW'(OSR - TOL))  && (ivl_q <= IW'(OSR + TOL));
    end

    // Classify the current edge.
    always_comb begin
        edge_o = (level_i != level_d);
        rise_o = level_i;
        if (!edge_o)       cls_o = IV_NONE;
        else if (in_long)  cls_o = IV_LONG;
        else if (in_short) cls_o = IV_SHORT;
        else               cls_o = IV_BAD;
    end

endmodule

// File: rtl/mrx_squelch.sv
// Pulse-width squelch and mid-bit tracker.
// Counts consecutive valid-spacing edges, keeps track of whether the last
// edge was mid-bit, opens after OPEN_CNT valid edges ending on a mid-bit
// edge, and closes after CLOSE_SAMPLES samples without a mid-bit edge.
module mrx_squelch
    import mrx_pkg::*;
#(
    parameter int OPEN_CNT      = 4,
    parameter int CLOSE_SAMPLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       edge_i,
    input  ivl_class_t cls_i,
    output logic       mid_o,
    output logic       open_o
);
    localparam int CW = $clog2(OPEN_CNT + 1);
    localparam int GW = $clog2(CLOSE_SAMPLES + 1);

    logic [CW-1:0] cnt_q, cnt_inc;
    logic [GW-1:0] gap_q;
    logic          known_q, last_mid_q, open_q;
    logic          is_short, is_long, mid_now, do_open, do_close;

    // Decide the class of this edge and the squelch transitions.
    always_comb begin
        is_short = edge_i && (cls_i == IV_SHORT);
        is_long  = edge_i && (cls_i == IV_LONG);
        mid_now  = is_long || (is_short && known_q && !last_mid_q);
        cnt_inc  = (cnt_q == CW'(OPEN_CNT)) ? cnt_q : cnt_q + 1'b1;
        do_open  = !open_q && (is_short || is_long) && mid_now
                   && (cnt_inc == CW'(OPEN_CNT));
        do_close = open_q && !mid_now && (gap_q == GW'(CLOSE_SAMPLES - 1));
    end

    // Qualification count and phase knowledge; closing clears both.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            known_q    <= 1'b0;
            last_mid_q <= 1'b0;
        end else if (do_close) begin
            cnt_q   <= '0;
            known_q <= 1'b0;
        end else if (is_long) begin
            cnt_q      <= cnt_inc;
            known_q    <= 1'b1;
            last_mid_q <= 1'b1;
        end else if (is_short) begin
            cnt_q      <= cnt_inc;
            last_mid_q <= !last_mid_q;
        end else if (edge_i) begin
            cnt_q   <= '0;
            known_q <= 1'b0;
        end
    end

    // Samples since the last mid-bit edge, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= GW'(CLOSE_SAMPLES);
        end else if (mid_now) begin
            gap_q <= '0;
        end else if (gap_q != GW'(CLOSE_SAMPLES)) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // Squelch state.
    always_ff @(posedge clk) begin
        if (!rst_n)        open_q <= 1'b0;
        else if (do_open)  open_q <= 1'b1;
        else if (do_close) open_q <= 1'b0;
    end

    assign mid_o  = mid_now;
    assign open_o = open_q;

endmodule

// File: rtl/mrx_bit_clock.sv
// Free-running bit phase counter. Reloaded to mid-bit on every recognised
// mid-bit edge; the bit clock is high for the second half of the bit.
// Assumes OSR is even.
module mrx_bit_clock #(
    parameter int OSR = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic resync_i,
    output logic bclk_o
);
    localparam int HALF = OSR / 2;
    localparam int PW   = $clog2(OSR);

    logic [PW-1:0] phase_q;

    // Advance the phase modulo OSR, snapping to mid-bit on resync.
    always_ff @(posedge clk) begin
        if (!rst_n)                         phase_q <= '0;
        else if (resync_i)                  phase_q <= PW'(HALF);
        else if (phase_q == PW'(OSR - 1))   phase_q <= '0;
        else                                phase_q <= phase_q + 1'b1;
    end

    assign bclk_o = (phase_q >= PW'(HALF));

endmodule

// File: rtl/manch_rx.sv
// Manchester receive decoder for an oversampled line.
// Chain: width filter -> edge timer -> squelch/mid tracker -> registered
// bit output; a free-running bit clock is resynchronised by mid-bit edges.
// Assumes one line sample per clk and OSR samples per nominal bit.
module manch_rx #(
    parameter int OSR        = 8,
    parameter int MIN_PULSE  = 3,
    parameter int TOL        = 1,
    parameter int OPEN_CNT   = 4,
    parameter int CLOSE_BITS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic rx_clk,
    output logic rx_data,
    output logic rx_valid,
    output logic carrier
);
    import mrx_pkg::*;

    localparam int CLOSE_SAMPLES = CLOSE_BITS * OSR;

    logic       flt_lvl;
    logic       edge_w, rise_w, mid_w, open_w;
    ivl_class_t cls_w;
    logic       data_q, valid_q;

    mrx_glitch_filter #(.MIN_PULSE(MIN_PULSE)) u_flt (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     (line_in),
        .level_o (flt_lvl)
    );

    mrx_edge_timer #(.OSR(OSR), .TOL(TOL)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (flt_lvl),
        .edge_o  (edge_w),
        .rise_o  (rise_w),
        .cls_o   (cls_w)
    );

    mrx_squelch #(.OPEN_CNT(OPEN_CNT), .CLOSE_SAMPLES(CLOSE_SAMPLES)) u_sq (
        .clk    (clk),
        .rst_n  (rst_n),
        .edge_i (edge_w),
        .cls_i  (cls_w),
        .mid_o  (mid_w),
        .open_o (open_w)
    );

    mrx_bit_clock #(.OSR(OSR)) u_bclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .resync_i (mid_w),
        .bclk_o   (rx_clk)
    );

    // Emit one bit per mid-bit edge seen while the squelch was already open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            data_q  <= 1'b0;
        end else begin
            valid_q <= open_w && mid_w;
            if (open_w && mid_w) data_q <= rise_w;
        end
    end

    assign rx_data  = data_q;
    assign rx_valid = valid_q;
    assign carrier  = open_w;

endmodule

// File: rtl/mrx_checker.sv
// Property checker for manch_rx, attached by bind.
module mrx_checker #(
    parameter int OSR = 8
) (
    input logic clk,
    input logic rst_n,
    input logic line_in,
    input logic flt_lvl,
    input logic rx_clk,
    input logic rx_valid,
    input logic carrier
);
    localparam int RW = $clog2(2 * OSR + 2);

    logic          bclk_d;
    logic [RW-1:0] run_q;

    // Length of the current constant run of the bit clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_d <= 1'b0;
            run_q  <= '0;
        end else begin
            bclk_d <= rx_clk;
            if (rx_clk != bclk_d)                 run_q <= '0;
            else if (run_q != RW'(2 * OSR + 1))   run_q <= run_q + 1'b1;
        end
    end

    AST_GLITCH_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(flt_lvl) |-> ($past(line_in) == flt_lvl && $past(line_in, 2) == flt_lvl)); // R2
    AST_OPEN_NO_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(carrier) |-> !rx_valid); // R5
    AST_VALID_IN_CARRIER: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> carrier); // R6
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R6
    AST_CLK_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RW'(OSR)); // R8
    AST_VALID_ON_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> rx_clk); // R9

endmodule

bind manch_rx mrx_checker #(.OSR(OSR)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_in  (line_in),
    .flt_lvl  (flt_lvl),
    .rx_clk   (rx_clk),
    .rx_valid (rx_valid),
    .carrier  (carrier)
);

// File: tb/sim_manch_rx.sv
`timescale 1ns/1ps
module sim_manch_rx;
    logic clk = 1'b0;
    logic rst_n;
    logic line_in;
    logic rx_clk, rx_data, rx_valid, carrier;

    int checks = 0;
    int errors = 0;
    bit exp_q[$];
    bit saw_carrier = 1'b0;

    always #2.5 clk = ~clk;

    manch_rx u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_in  (line_in),
        .rx_clk   (rx_clk),
        .rx_data  (rx_data),
        .rx_valid (rx_valid),
        .carrier  (carrier)
    );

    task automatic chk(input bit ok, input string req, input int act,
                       input int exp, input string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // One line sample per cycle, changed away from the active edge.
    task automatic drive(input bit v, input int n);
        repeat (n) begin
            @(negedge clk);
            line_in = v;
        end
    endtask

    // One Manchester bit; gl flips samples 1..2 of the first half.
    task automatic send_bit(input bit b, input int h1, input int h2,
                            input bit gl, input bit expect_out);
        if (expect_out) exp_q.push_back(b);
        for (int k = 0; k < h1; k++) begin
            @(negedge clk);
            line_in = (gl && (k == 1 || k == 2)) ? b : !b;
        end
        drive(b, h2);
    endtask

    // Alternating preamble of 16 bits from low idle, then the payload.
    task automatic send_frame(input logic [31:0] word, input int n,
                              input bit jitter, input int glitch_at);
        for (int i = 0; i < 16; i++) send_bit((i % 2) == 0, 4, 4, 1'b0, i >= 5);
        for (int i = 0; i < n; i++) begin
            send_bit(word[n-1-i], 4, jitter ? 3 + (i % 3) : 4, i == glitch_at, 1'b1);
        end
        drive(1'b0, 1);
    endtask

    task automatic count_rises(input int n, output int c);
        bit prev;
        c = 0;
        @(negedge clk);
        prev = rx_clk;
        repeat (n) begin
            @(negedge clk);
            if (rx_clk && !prev) c++;
            prev = rx_clk;
        end
    endtask

    // After a frame: carrier still up half a bit later, then closes; all bits out.
    task automatic end_of_frame(input string tag);
        drive(1'b0, 3);
        chk(carrier == 1'b1, "R7", carrier, 1, {tag, " carrier soon after frame"});
        drive(1'b0, 30);
        chk(carrier == 1'b0, "R7", carrier, 0, {tag, " carrier after silence"});
        chk(exp_q.size() == 0, "R6", exp_q.size(), 0, {tag, " bits left unmatched"});
    endtask

    // Scoreboard monitor: pop and compare every decoded bit.
    always @(negedge clk) begin
        if (carrier) saw_carrier = 1'b1;
        if (rst_n && rx_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R6", 1, 0, "strobe with no expected bit");
            end else begin
                bit e;
                e = exp_q.pop_front();
                chk(rx_data == e, "R4", rx_data, e, "decoded bit");
            end
            chk(rx_clk == 1'b1, "R9", rx_clk, 1, "bit clock at strobe");
            chk(carrier == 1'b1, "R6", carrier, 1, "strobe outside carrier");
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1, "run did not finish");
        finish_run();
    end

    initial begin
        int c;
        line_in = 1'b0;
        rst_n   = 1'b0;
        repeat (4) @(negedge clk);
        chk(carrier == 1'b0, "R1", carrier, 0, "carrier in reset");
        chk(rx_valid == 1'b0, "R1", rx_valid, 0, "valid in reset");
        chk(rx_clk == 1'b0, "R1", rx_clk, 0, "bit clock in reset");
        rst_n = 1'b1;

        // R8: free-running bit clock while idle.
        count_rises(80, c);
        chk(c == 10, "R8", c, 10, "bit clock rises in idle");

        // R2: short noise pulses in idle.
        saw_carrier = 1'b0;
        for (int i = 0; i < 10; i++) begin
            drive(1'b1, 1 + (i % 2));
            drive(1'b0, 10);
        end
        chk(saw_carrier == 1'b0, "R2", saw_carrier, 0, "carrier from glitches");

        // R3: valid-width pulses with bad spacing never qualify.
        for (int i = 0; i < 8; i++) begin
            drive(1'b1, 4);
            drive(1'b0, 13);
        end
        chk(saw_carrier == 1'b0, "R3", saw_carrier, 0, "carrier from spaced pulses");

        // R3: four bits give only three valid transitions.
        for (int i = 0; i < 4; i++) send_bit((i % 2) == 0, 4, 4, 1'b0, 1'b0);
        drive(1'b0, 30);
        chk(saw_carrier == 1'b0, "R3", saw_carrier, 0, "carrier after 3 valid edges");

        // R5: five bits open the squelch but yield no bit.
        for (int i = 0; i < 5; i++) send_bit((i % 2) == 0, 4, 4, 1'b0, 1'b0);
        drive(1'b0, 30);
        chk(saw_carrier == 1'b1, "R3", saw_carrier, 0 + 1, "carrier after 4 valid edges");
        chk(carrier == 1'b0, "R7", carrier, 0, "carrier closed after short burst");

        // R8: clock still free-running in the gap.
        count_rises(80, c);
        chk(c == 10, "R8", c, 10, "bit clock rises between frames");

        // R4 main frame.
        send_frame(32'hD2B4_1E69, 32, 1'b0, -1);
        end_of_frame("plain");

        // R9 jittered bit lengths.
        send_frame(32'h9C3A_65F0, 32, 1'b1, -1);
        end_of_frame("jitter");

        // R2 glitch inside a long constant run during a frame.
        send_frame(32'h0000_A3C5, 16, 1'b0, 1);
        end_of_frame("glitch");

        // R10 run of ones: boundary transitions give no bits.
        send_frame(32'h0000_FFFF, 16, 1'b0, -1);
        end_of_frame("ones");

        // R10 run of zeros.
        send_frame(32'h0000_0000, 12, 1'b0, -1);
        end_of_frame("zeros");

        finish_run();
    end

endmodule